// File: doc/BRIEF.md
# Tree Destination Hop Router

Each node in a tree of devices has one copy of this block. It picks the next hop for every outgoing request. A request carries a channel number, and the upper field of that number names a destination. The destination selects a route from a table held inside the block. A route is a short list of hops that starts at the root of the tree. The node reads the element at the index equal to its own rank (its depth in the tree). Hop 0 delivers the request to the local core. Hop k forwards it to downstream port k.

The route table is filled entry by entry through a write port while links are being brought up. Until the first entry is written, the block uses a built-in star layout:
- Destination 0 is the local core.
- Destination n goes out on port n and ends at the local core of the device on that port.

The block rejects a request and raises a one-cycle error strobe instead of a hop output when any of the following holds:
- the route is missing or malformed;
- the route points past the last port;
- the link on the chosen port is down.

The decision always takes exactly one clock, whatever the data, so each hop adds a fixed delay.

Top module: `hop_router`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `out_valid` is all zero and `out_err` is low. No table is loaded after reset, so the star layout applies.
- R2: The destination is taken from bits 24..16 of `req_chan`. Bits 15..0 of the request appear on `out_chan` together with the hop output.
- R3: A request accepted at a clock edge produces, at the next edge, exactly one result: a single `out_valid` bit or `out_err`. A cycle with no request produces neither at the next edge. Back-to-back requests are handled every cycle.
- R4: Hop value 0 raises `out_valid[0]` (the local core). Hop value k, for 1 ≤ k ≤ NUM_PORTS, raises `out_valid[k]` (downstream port k).
- R5: With no table loaded and rank 0, the results are:
  - destination 0 gives hop 0;
  - destination n with 1 ≤ n ≤ NUM_PORTS gives hop n;
  - any other destination gives an error.
- R6: With no table loaded and rank 1 or more, the results are:
  - destination n with 1 ≤ n ≤ NUM_PORTS gives hop 0 at rank 1;
  - destination 0 gives an error at any rank of 1 or more.
- R7: With a table loaded, the hop is element `rank` of the route stored for the destination. Element i sits in bits [3i+2:3i] of `tbl_wr_route`.
- R8: The first write to the table leaves star mode, so every destination not yet written becomes unreachable. A write takes effect from the cycle after it. A request in the same cycle as the write still sees the old entry.
- R9: A route is rejected in either of these cases:
  - none of its 8 elements is 0;
  - an element below index `rank` is already 0, meaning the route ended before this node.
- R10: A hop value above NUM_PORTS gives an error.
- R11: A request is dropped with `out_err` when the chosen downstream port has `link_up` low. `link_up[k-1]` belongs to port k.
- R12: With a table loaded, a destination at or above NUM_DEST (16) gives an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_chan | input | 25 | Channel number: destination in 24..16, local channel in 15..0 |
| rank | input | 3 | Depth of this node in the tree (root is 0) |
| link_up | input | 4 | Link status of downstream ports 1..4 (bit k-1 for port k) |
| tbl_wr_en | input | 1 | Write one route table entry |
| tbl_wr_dest | input | 4 | Destination index to write |
| tbl_wr_route | input | 24 | Route, 8 elements of 3 bits, element 0 in the low bits |
| out_valid | output | 5 | One-hot hop output: bit 0 local core, bit k port k |
| out_chan | output | 16 | Channel within the destination, registered with the decision |
| out_err | output | 1 | Request dropped: unreachable or link down |

## Verification
Every hop decision and every error strobe is due one clock edge after the edge that captured its request. A table write changes only decisions made for requests captured at later edges. The driver applies each request or write at a falling edge and queues the expected result. The monitor removes one entry per rising edge and compares it 2 ns later, so each check lands on the cycle the design must produce. Idle cycles also queue an entry expecting no output, which catches late, early or duplicate results.

// File: rtl/hop_router.sv
module hop_router #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_DEST  = 16,
  parameter int MAX_HOPS  = 8,
  parameter int HOP_W     = 3,
  parameter int CHAN_W    = 25,
  parameter int LCH_W     = 16,
  localparam int RANK_W   = $clog2(MAX_HOPS),
  localparam int DIDX_W   = $clog2(NUM_DEST),
  localparam int ROUTE_W  = MAX_HOPS * HOP_W,
  localparam int DST_W    = CHAN_W - LCH_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CHAN_W-1:0]    req_chan,
  input  logic [RANK_W-1:0]    rank,
  input  logic [NUM_PORTS-1:0] link_up,
  input  logic                 tbl_wr_en,
  input  logic [DIDX_W-1:0]    tbl_wr_dest,
  input  logic [ROUTE_W-1:0]   tbl_wr_route,
  output logic [NUM_PORTS:0]   out_valid,
  output logic [LCH_W-1:0]     out_chan,
  output logic                 out_err
);

  localparam logic [DST_W-1:0] NDEST_D = DST_W'(NUM_DEST);
  localparam logic [DST_W-1:0] NPORT_D = DST_W'(NUM_PORTS);
  localparam logic [HOP_W-1:0] NPORT_H = HOP_W'(NUM_PORTS);

  logic [ROUTE_W-1:0] tbl [NUM_DEST];
  logic [NUM_DEST-1:0] ent_vld;
  logic                loaded;

  wire [DST_W-1:0] dest = req_chan[CHAN_W-1:LCH_W];

  logic [ROUTE_W-1:0] route;
  logic               route_ok;
  logic               any_zero, zero_early;
  logic [HOP_W-1:0]   hop;
  logic [NUM_PORTS:0] hop_oh;
  logic               link_ok;
  logic               ok;

  always_comb begin
    route    = '0;
    route_ok = 1'b0;
    if (!loaded) begin
      if (dest == '0) begin
        route_ok = 1'b1;
      end else if (dest <= NPORT_D) begin
        route[HOP_W-1:0] = HOP_W'(dest);
        route_ok = 1'b1;
      end
    end else if (dest < NDEST_D) begin
      route    = tbl[dest[DIDX_W-1:0]];
      route_ok = ent_vld[dest[DIDX_W-1:0]];
    end
  end

  always_comb begin
    any_zero   = 1'b0;
    zero_early = 1'b0;
    hop        = '0;
    for (int i = 0; i < MAX_HOPS; i++) begin
      if (route[i*HOP_W +: HOP_W] == '0) begin
        any_zero = 1'b1;
        if (RANK_W'(i) < rank) zero_early = 1'b1;
      end
      if (RANK_W'(i) == rank) hop = route[i*HOP_W +: HOP_W];
    end
  end

  always_comb begin
    hop_oh  = '0;
    link_ok = 1'b0;
    for (int k = 0; k <= NUM_PORTS; k++) begin
      if (hop == HOP_W'(k)) begin
        hop_oh[k] = 1'b1;
        link_ok   = (k == 0) ? 1'b1 : link_up[(k == 0) ? 0 : k-1];
      end
    end
  end

  assign ok = route_ok && any_zero && !zero_early && (hop <= NPORT_H) && link_ok;

  always_ff @(posedge clk) begin
    if (tbl_wr_en) tbl[tbl_wr_dest] <= tbl_wr_route;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_err   <= 1'b0;
      out_chan  <= '0;
      loaded    <= 1'b0;
      ent_vld   <= '0;
    end else begin
      out_valid <= (req_valid && ok) ? hop_oh : '0;
      out_err   <= req_valid && !ok;
      out_chan  <= req_chan[LCH_W-1:0];
      if (tbl_wr_en) begin
        loaded               <= 1'b1;
        ent_vld[tbl_wr_dest] <= 1'b1;
      end
    end
  end

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((|out_valid) != out_err));

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|out_valid) || out_err) |-> $past(req_valid));

  generate
    for (genvar g = 1; g <= NUM_PORTS; g++) begin : g_link_chk
      assert_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[g] |-> $past(link_up[g-1]));
    end
  endgenerate

endmodule

// File: tb/tb_hop_router.sv
module tb_hop_router;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [24:0] req_chan = '0;
  logic [2:0]  rank = '0;
  logic [3:0]  link_up = 4'hF;
  logic        tbl_wr_en = 1'b0;
  logic [3:0]  tbl_wr_dest = '0;
  logic [23:0] tbl_wr_route = '0;
  logic [P:0]  out_valid;
  logic [15:0] out_chan;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [P:0]  q_ov[$];
  logic        q_err[$];
  logic [15:0] q_chan[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  hop_router dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .rank(rank), .link_up(link_up), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_dest(tbl_wr_dest), .tbl_wr_route(tbl_wr_route),
    .out_valid(out_valid), .out_chan(out_chan), .out_err(out_err)
  );

  // exp_hop: -1 nothing expected, -2 error expected, else hop number
  task automatic cyc(input logic rv, input logic [8:0] dst, input logic [15:0] lch,
                     input logic [2:0] rk, input logic [3:0] lk,
                     input logic we, input logic [3:0] wd, input logic [23:0] wr,
                     input int exp_hop, input string tag);
    @(negedge clk);
    req_valid    = rv;
    req_chan     = {dst, lch};
    rank         = rk;
    link_up      = lk;
    tbl_wr_en    = we;
    tbl_wr_dest  = wd;
    tbl_wr_route = wr;
    q_ov.push_back((exp_hop >= 0) ? (P+1)'(1 << exp_hop) : '0);
    q_err.push_back(exp_hop == -2);
    q_chan.push_back(lch);
    q_tag.push_back(tag);
  endtask

  task automatic req(input logic [8:0] dst, input logic [15:0] lch, input logic [2:0] rk,
                     input logic [3:0] lk, input int exp_hop, input string tag);
    cyc(1'b1, dst, lch, rk, lk, 1'b0, 4'd0, 24'd0, exp_hop, tag);
  endtask

  task automatic wr(input logic [3:0] wd, input logic [23:0] route, input int exp_hop,
                    input logic [8:0] dst, input logic rv, input string tag);
    cyc(rv, dst, 16'h0, 3'd0, 4'hF, 1'b1, wd, route, exp_hop, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 9'd0, 16'h0, 3'd0, 4'hF, 1'b0, 4'd0, 24'd0, -1, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_ov.size() > 0) begin
      logic [P:0] eov;
      logic       eerr;
      logic [15:0] ech;
      string      t;
      eov = q_ov.pop_front(); eerr = q_err.pop_front();
      ech = q_chan.pop_front(); t = q_tag.pop_front();
      checks++;
      if (out_valid !== eov || out_err !== eerr ||
          (eov != '0 && out_chan !== ech)) begin
        errors++;
        $display("FAIL %s: out_valid=%b out_err=%b out_chan=%h expected out_valid=%b out_err=%b out_chan=%h",
                 t, out_valid, out_err, out_chan, eov, eerr, ech);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== '0 || out_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: out_valid=%b out_err=%b expected 0 0", out_valid, out_err);
    end
    rst_n = 1'b1;
    idle("R1 idle after reset");
    // star layout, rank 0
    req(9'd0, 16'h1234, 3'd0, 4'hF, 0, "R5 R2 dest0 local");
    req(9'd1, 16'hBEEF, 3'd0, 4'hF, 1, "R5 dest1 port1");
    req(9'd4, 16'h0042, 3'd0, 4'hF, 4, "R4 dest4 port4");
    req(9'd5, 16'h0001, 3'd0, 4'hF, -2, "R5 dest beyond ports");
    idle("R3 no request no result");
    req(9'd3, 16'hABCD, 3'd0, 4'hF, 3, "R2 dest3 chan field");
    // link status
    req(9'd2, 16'h0002, 3'd0, 4'b1101, -2, "R11 port2 link down");
    req(9'd1, 16'h0003, 3'd0, 4'b1101, 1, "R11 port1 still up");
    // star layout, deeper ranks
    req(9'd3, 16'h0010, 3'd1, 4'hF, 0, "R6 rank1 dest3 local");
    req(9'd0, 16'h0011, 3'd1, 4'hF, -2, "R6 rank1 dest0");
    req(9'd2, 16'h0012, 3'd2, 4'hF, -2, "R6 rank2 dest2");
    // load table
    wr(4'd2, 24'o31, -1, 9'd0, 1'b0, "R8 write dest2");
    req(9'd3, 16'h0020, 3'd0, 4'hF, -2, "R8 unwritten dest after load");
    wr(4'd5, 24'o11111111, -1, 9'd0, 1'b0, "R8 write dest5");
    wr(4'd6, 24'o7, -1, 9'd0, 1'b0, "R8 write dest6");
    wr(4'd7, 24'o2, -1, 9'd0, 1'b0, "R8 write dest7");
    req(9'd2, 16'h0030, 3'd0, 4'hF, 1, "R7 dest2 rank0");
    req(9'd2, 16'h0031, 3'd1, 4'hF, 3, "R7 dest2 rank1");
    req(9'd2, 16'h0032, 3'd2, 4'hF, 0, "R7 dest2 rank2");
    req(9'd2, 16'h0033, 3'd3, 4'hF, -2, "R9 route ended before rank");
    req(9'd5, 16'h0034, 3'd0, 4'hF, -2, "R9 no terminating zero");
    req(9'd6, 16'h0035, 3'd0, 4'hF, -2, "R10 hop above port count");
    req(9'd20, 16'h0036, 3'd0, 4'hF, -2, "R12 dest beyond table");
    req(9'd7, 16'h0037, 3'd0, 4'hF, 2, "R7 dest7 rank0");
    // write and request same cycle
    wr(4'd9, 24'o4, -2, 9'd9, 1'b1, "R8 same-cycle write not yet visible");
    req(9'd9, 16'h0040, 3'd0, 4'hF, 4, "R8 write visible next cycle");
    req(9'd7, 16'h0041, 3'd0, 4'b1101, -2, "R11 loaded route link down");
    idle("R3 tail idle");
    idle("R3 tail idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule